// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing controller of a 512-byte serial EEPROM. It listens on an already synchronized two-wire bus (SCL and SDA), recognises bus START and STOP conditions, and decodes the address byte that follows each START. It then serves byte writes, page writes of up to 16 bytes, current-address reads, random reads and sequential reads. The storage is modelled as a register array. Writes are collected in a one-page staging buffer and copied into the array when the master ends the transfer with STOP.

The block has one internal address pointer, which always holds the last byte touched plus one. SDA is driven open-drain: the block only ever pulls the line low, and it does so through `sda_oe`. The block's SDA input must see the wired-AND of the master's drive and this pull-down. After a committed write, the controller is busy for a parameterised number of system clocks. During that time it ignores the bus completely, so a master can poll for completion by sending address bytes until one is acknowledged. A `write_allowed` input from a supply-lockout circuit decides at STOP whether staged data may reach the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is low, every array byte reads as 0x00, and the address pointer is 0.
- R2: The address byte is taken MSB first. Bits 7:4 must equal 1010 for the block to respond, and bits 3:2 are ignored. Bit 1 is the bank bit, which becomes address bit 8 of a word address. Bit 0 selects the direction: 1 is read, 0 is write. Any other value of bits 7:4 gets no acknowledge, and the block then stays silent until the next START.
- R3: On the ninth SCL pulse the block pulls SDA low to acknowledge each of the following: a matching address byte, the word-address byte, and every write data byte.
- R4: A write consists of an address byte with bit 0 = 0, then a word-address byte carrying bits 7:0, then one data byte, then STOP. This stores the data at {bank bit, word address}.
- R5: Within a page write, only the low four address bits advance after each data byte, and the upper five bits stay fixed. A 17th byte and any later bytes wrap to the start of the same 16-byte page and overwrite the bytes staged there.
- R6: STOP after at least one data byte, with `write_allowed` high, starts an internal write cycle of WR_CYCLES clocks. During that cycle no address byte is acknowledged and SDA is never pulled low. After the cycle ends, the block acknowledges again.
- R7: If `write_allowed` is low at STOP, the staged bytes are discarded and the array is unchanged. No write cycle starts, so the next address byte is acknowledged at once. The address pointer still moves as if the write had been accepted.
- R8: A current-address read (address byte with bit 0 = 1 straight after START) returns the byte at the pointer and ignores the bank bit. Afterwards the pointer equals the address that was read plus one.
- R9: A random read is a write address byte plus a word-address byte, then a repeated START and a read address byte. It returns the byte at the given 9-bit address.
- R10: In a read, each master acknowledge (SDA low on the ninth pulse) causes the next byte to be sent. The full 9-bit address advances, and it wraps from 0x1FF to 0x000.
- R11: Read data is sent MSB first, and `sda_oe` changes only while SCL is low. After the master withholds its acknowledge, the block does not pull SDA low again until the next START.
- R12: A write transfer that ends with STOP after the word-address byte loads the pointer with that address. It writes nothing and starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scl | input | 1 | Synchronized bus clock |
| sda_in | input | 1 | Synchronized bus data line (wired-AND of all drivers) |
| write_allowed | input | 1 | High when the supply permits array updates; sampled at STOP |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or a zero data bit) |

## Verification
The hardest state to reach from the ports is the case where a page write has been staged and acknowledged but `write_allowed` is low at STOP. In that state the array must stay unchanged while the pointer still advances. The bench first writes known bytes over a page, then repeats the write with the lockout input low. It then reads back through a current-address read, which shows the advanced pointer, and through a random read, which shows the old contents. A second hard case is a page write that wraps inside its 16-byte page, together with a sequential read that wraps from the top address to 0. Directed transfers reach both cases, and seeded random writes and reads, some of them with the lockout low, are checked against a bench model of the array and the pointer.

// File: rtl/eep_pkg.sv
// Package: shared types and fixed protocol constants for the EEPROM slave.
// Assumes an 8-bit address byte laid out as {id[3:0], ignored[1:0], bank, rw}.
package eep_pkg;

    localparam logic [3:0] DEV_ID = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_RNEXT,
        ST_BUSY
    } ctrl_st_t;

    typedef enum logic [1:0] {
        RX_DEV,
        RX_WADDR,
        RX_WDATA
    } rx_kind_t;

endpackage

// File: rtl/eep_bus_events.sv
// Module: turns synchronized SCL/SDA levels into single-cycle bus events.
// Assumes both inputs are already synchronous to clk; bus idles high.
module eep_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic ev_start,
    output logic ev_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    // Remember the previous line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Data edges while SCL stays high frame a transfer; SCL edges clock bits.
    always_comb begin
        ev_start = scl_q & scl & sda_q & ~sda;
        ev_stop  = scl_q & scl & ~sda_q & sda;
        scl_rise = ~scl_q & scl;
        scl_fall = scl_q & ~scl;
    end
endmodule

// File: rtl/eep_wr_timer.sv
// Module: counts out the internal write cycle after a commit.
// Assumes CYCLES >= 1; busy is high for exactly CYCLES clocks after kick.
module eep_wr_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load on kick, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (kick) begin
            cnt <= CNT_W'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/eep_store.sv
// Module: byte array plus a one-page staging buffer with per-byte valid bits.
// Assumes commit and drop are never high together; page is stable while
// bytes are staged and at commit.
module eep_store #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stage_we,
    input  logic [PAGE_W-1:0]        stage_idx,
    input  logic [DATA_W-1:0]        stage_data,
    input  logic                     drop,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     pending
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DATA_W-1:0]     mem     [DEPTH];
    logic [DATA_W-1:0]     pg_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pg_mask;

    // Staging data per slot; a later byte to the same slot overwrites it.
    always_ff @(posedge clk) begin
        if (stage_we) begin
            pg_data[stage_idx] <= stage_data;
        end
    end

    // Track which page slots hold staged bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_mask <= '0;
        end else if (drop || commit) begin
            pg_mask <= '0;
        end else if (stage_we) begin
            pg_mask[stage_idx] <= 1'b1;
        end
    end

    // Array: cleared by reset, updated in one step from the staged page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pg_mask[i]) begin
                    mem[{page, PAGE_W'(i)}] <= pg_data[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign pending = |pg_mask;
endmodule

// File: rtl/eep_ctrl.sv
// Module: bus protocol engine - address decode, acknowledge, shift in/out,
// address pointer and write-cycle entry.
// Assumes event inputs from eep_bus_events and a busy flag from the timer.
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ev_start,
    input  logic                     ev_stop,
    input  logic                     scl_rise,
    input  logic                     scl_fall,
    input  logic                     sda,
    input  logic                     write_allowed,
    input  logic                     busy,
    input  logic [DATA_W-1:0]        rd_data,
    input  logic                     pending,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic                     stage_we,
    output logic [PAGE_W-1:0]        stage_idx,
    output logic [DATA_W-1:0]        stage_data,
    output logic                     drop,
    output logic                     commit,
    output logic [ADDR_W-PAGE_W-1:0] page,
    output logic                     sda_oe
);
    localparam int              BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    ctrl_st_t          state;
    rx_kind_t          kind;
    logic [BIT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              ack_on;
    logic              rw_q;
    logic              bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rx_byte;
    logic              byte_done;
    logic              bus_live;

    // Derived strobes for the byte in flight and the array interface.
    always_comb begin
        rx_byte    = {shreg[DATA_W-2:0], sda};
        byte_done  = (state == ST_RX) && scl_rise && (bitcnt == BIT_LAST);
        bus_live   = (state != ST_BUSY);
        commit     = bus_live && ev_stop && pending && write_allowed;
        drop       = bus_live && (ev_start || ev_stop) && !commit;
        stage_we   = byte_done && (kind == RX_WDATA);
        stage_idx  = addr_q[PAGE_W-1:0];
        stage_data = rx_byte;
        page       = addr_q[ADDR_W-1:PAGE_W];
        rd_addr    = addr_q;
        sda_oe     = ((state == ST_ACK) && ack_on) || ((state == ST_TX) && !shreg[DATA_W-1]);
    end

    // Main sequencer: framing first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= RX_DEV;
            bitcnt <= '0;
            shreg  <= '0;
            ack_on <= 1'b0;
            rw_q   <= 1'b0;
            bank_q <= 1'b0;
            addr_q <= '0;
        end else if (state == ST_BUSY) begin
            if (!busy) begin
                state <= ST_IDLE;
            end
        end else if (commit) begin
            state  <= ST_BUSY;
            ack_on <= 1'b0;
        end else if (ev_stop) begin
            state  <= ST_IDLE;
            ack_on <= 1'b0;
        end else if (ev_start) begin
            state  <= ST_RX;
            kind   <= RX_DEV;
            bitcnt <= '0;
            ack_on <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg  <= rx_byte;
                        bitcnt <= bitcnt + BIT_W'(1);
                        if (bitcnt == BIT_LAST) begin
                            unique case (kind)
                                RX_DEV: begin
                                    if (rx_byte[7:4] == DEV_ID) begin
                                        rw_q   <= rx_byte[0];
                                        bank_q <= rx_byte[1];
                                        state  <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                RX_WADDR: begin
                                    addr_q <= {bank_q, rx_byte};
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                                    state              <= ST_ACK;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_on) begin
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            bitcnt <= '0;
                            if (kind == RX_DEV && rw_q) begin
                                shreg  <= rd_data;
                                addr_q <= addr_q + ADDR_W'(1);
                                state  <= ST_TX;
                            end else if (kind == RX_DEV) begin
                                kind  <= RX_WADDR;
                                state <= ST_RX;
                            end else begin
                                kind  <= RX_WDATA;
                                state <= ST_RX;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == BIT_LAST) begin
                            bitcnt <= '0;
                            state  <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[DATA_W-2:0], 1'b0};
                            bitcnt <= bitcnt + BIT_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        state <= sda ? ST_IDLE : ST_RNEXT;
                    end
                end
                ST_RNEXT: begin
                    if (scl_fall) begin
                        shreg  <= rd_data;
                        addr_q <= addr_q + ADDR_W'(1);
                        state  <= ST_TX;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Module: top of the EEPROM slave; wires event detect, protocol engine,
// storage and write-cycle timer.
// Assumes scl/sda_in are synchronized and sda_in is the wired-AND bus level.
module i2c_eeprom_slave #(
    parameter int ADDR_W    = 9,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    input  logic write_allowed,
    output logic sda_oe
);
    localparam int PAGE_SEL_W = ADDR_W - PAGE_W;

    logic                  ev_start;
    logic                  ev_stop;
    logic                  scl_rise;
    logic                  scl_fall;
    logic                  busy;
    logic                  commit;
    logic                  drop;
    logic                  stage_we;
    logic [PAGE_W-1:0]     stage_idx;
    logic [DATA_W-1:0]     stage_data;
    logic [PAGE_SEL_W-1:0] page;
    logic [ADDR_W-1:0]     rd_addr;
    logic [DATA_W-1:0]     rd_data;
    logic                  pending;

    eep_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl),
        .sda      (sda_in),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    eep_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_start      (ev_start),
        .ev_stop       (ev_stop),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .sda           (sda_in),
        .write_allowed (write_allowed),
        .busy          (busy),
        .rd_data       (rd_data),
        .pending       (pending),
        .rd_addr       (rd_addr),
        .stage_we      (stage_we),
        .stage_idx     (stage_idx),
        .stage_data    (stage_data),
        .drop          (drop),
        .commit        (commit),
        .page          (page),
        .sda_oe        (sda_oe)
    );

    eep_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .stage_we   (stage_we),
        .stage_idx  (stage_idx),
        .stage_data (stage_data),
        .drop       (drop),
        .commit     (commit),
        .page       (page),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .pending    (pending)
    );

    eep_wr_timer #(
        .CYCLES (WR_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (commit),
        .busy  (busy)
    );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
// Module: protocol checker bound onto the EEPROM slave top.
// Assumes a well-formed master that changes SDA only with SCL low, except
// for START and STOP.
module i2c_eeprom_slave_chk #(
    parameter int WR_CYCLES = 300
) (
    input logic clk,
    input logic rst_n,
    input logic scl,
    input logic write_allowed,
    input logic sda_oe,
    input logic busy,
    input logic ev_stop
);
    int busy_len;

    // Length of the current busy stretch, in clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= 0;
        end
    end

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe); // R6

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop)); // R6

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(busy)) |-> (busy_len == WR_CYCLES)); // R6

    AST_NO_CYCLE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(write_allowed)); // R7

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl); // R11
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl           (scl),
    .write_allowed (write_allowed),
    .sda_oe        (sda_oe),
    .busy          (busy),
    .ev_stop       (ev_stop)
);

// File: tb/sim_i2c_eeprom_slave.sv
// Bench: bus-master tasks drive the slave; a bench model of the array and
// pointer supplies every expected value.
module sim_i2c_eeprom_slave;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wa = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic ack;
    logic [7:0] rb;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model [512];
    logic [8:0] ptr = '0;
    logic [7:0] wbuf [32];

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_eeprom_slave u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl           (scl_m),
        .sda_in        (sda_line),
        .write_allowed (wa),
        .sda_oe        (sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [8:0] page_step(input logic [8:0] a, input int k);
        return {a[8:4], 4'(a[3:0] + k)};
    endfunction

    task automatic step();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; step();
        scl_m = 1'b1; step();
        sda_m = 1'b0; step();
        scl_m = 1'b0; step();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; step();
        scl_m = 1'b1; step();
        sda_m = 1'b1; step();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; step();
            scl_m = 1'b1; step();
            scl_m = 1'b0; step();
        end
        sda_m = 1'b1; step();
        scl_m = 1'b1; step();
        a = ~sda_line;
        scl_m = 1'b0; step();
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            step();
            scl_m = 1'b1; step();
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        step();
        sda_m = ~mack; step();
        scl_m = 1'b1; step();
        scl_m = 1'b0; step();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic bank, input logic rw);
        return {4'b1010, 2'($urandom), bank, rw};
    endfunction

    // Page/byte write through the bus; the model follows the requirements.
    task automatic do_write(input logic [8:0] a, input int n, input logic allowed);
        wa = allowed;
        bus_start();
        send_byte(dev_byte(a[8], 1'b0), ack); chk("R3 dev ack", ack, 1);
        send_byte(a[7:0], ack);               chk("R3 word ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack);          chk("R3 data ack", ack, 1);
        end
        bus_stop();
        if (allowed) begin
            for (int k = 0; k < n; k++) model[page_step(a, k)] = wbuf[k];
        end
        ptr = page_step(a, n);
        wa = 1'b1;
    endtask

    task automatic wait_ready(output int polls);
        polls = 0;
        ack = 1'b0;
        while (!ack && polls < 200) begin
            bus_start();
            send_byte(8'hA0, ack);
            bus_stop();
            polls++;
        end
    endtask

    task automatic read_bytes(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, rb);
            chk(req, rb, model[ptr]);
            ptr = ptr + 9'd1;
        end
        bus_stop();
    endtask

    task automatic rand_read(input logic [8:0] a, input int n, input string req);
        bus_start();
        send_byte(dev_byte(a[8], 1'b0), ack); chk("R9 dev ack", ack, 1);
        send_byte(a[7:0], ack);               chk("R9 word ack", ack, 1);
        bus_start();
        send_byte(dev_byte(1'b0, 1'b1), ack); chk("R9 read ack", ack, 1);
        ptr = a;
        read_bytes(n, req);
    endtask

    task automatic cur_read(input int n, input logic bank, input string req);
        bus_start();
        send_byte(dev_byte(bank, 1'b1), ack); chk("R8 read ack", ack, 1);
        read_bytes(n, req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        int polls;
        void'($urandom(32'd1234));
        for (int i = 0; i < 512; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 sda_oe after reset", sda_oe, 0);
        cur_read(1, 1'b0, "R1 zero array / pointer 0");

        // R2: foreign id gets no ack and the block stays silent.
        bus_start();
        send_byte(8'h52, ack); chk("R2 foreign id nack", ack, 0);
        send_byte(8'hA0, ack); chk("R2 silent until START", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hAC, ack); chk("R2 ignored bits set ack", ack, 1);
        bus_stop();

        // R4 byte write into bank 1, R6 polling during the write cycle.
        wbuf[0] = 8'hA5;
        do_write(9'h123, 1, 1'b1);
        bus_start();
        send_byte(8'hA0, ack); chk("R6 no ack while busy", ack, 0);
        bus_stop();
        wait_ready(polls);
        chk("R6 ack after write cycle", ack, 1);
        rand_read(9'h123, 1, "R4 byte write readback");

        // R5 page wrap: 18 bytes from low nibble 0xA.
        for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h40 + k * 3);
        do_write(9'h13A, 18, 1'b1);
        wait_ready(polls);
        rand_read(9'h130, 16, "R5 page wrap contents");

        // R7 lockout: prime bytes, then a locked rewrite.
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(k + 1);
        do_write(9'h050, 4, 1'b1);
        wait_ready(polls);
        for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'h11 * (k + 1));
        do_write(9'h050, 3, 1'b0);
        bus_start();
        send_byte(8'hA0, ack); chk("R7 no write cycle when locked", ack, 1);
        bus_stop();
        cur_read(1, 1'b1, "R7 R8 pointer advanced, bank bit ignored");
        rand_read(9'h050, 3, "R7 array unchanged");

        // R10 rollover from the top address.
        wbuf[0] = 8'h9D; wbuf[1] = 8'h9E;
        do_write(9'h1FE, 2, 1'b1);
        wait_ready(polls);
        rand_read(9'h1FE, 4, "R10 sequential rollover");
        cur_read(1, 1'b0, "R8 pointer after rollover");

        // R11: after master NACK no further pull-down.
        bus_start();
        send_byte(8'hA1, ack); chk("R11 read ack", ack, 1);
        recv_byte(1'b0, rb); chk("R11 MSB-first data", rb, model[ptr]);
        ptr = ptr + 9'd1;
        for (int k = 0; k < 9; k++) begin
            step(); scl_m = 1'b1; step();
            chk("R11 released after NACK", sda_oe, 0);
            scl_m = 1'b0;
        end
        step();
        bus_stop();

        // R12: address-only write sets pointer, no cycle.
        bus_start();
        send_byte(8'hA2, ack); chk("R12 dev ack", ack, 1);
        send_byte(8'h23, ack); chk("R12 word ack", ack, 1);
        bus_stop();
        ptr = 9'h123;
        bus_start();
        send_byte(8'hA0, ack); chk("R12 no write cycle", ack, 1);
        bus_stop();
        cur_read(1, 1'b0, "R12 pointer loaded");

        // Seeded random mix.
        for (int it = 0; it < 14; it++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) begin
                logic [8:0] a;
                int n;
                logic al;
                a  = 9'($urandom);
                n  = 1 + int'($urandom % 20);
                al = (($urandom % 4) != 0);
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                do_write(a, n, al);
                if (al) wait_ready(polls);
                cur_read(1, 1'b0, "R5 R8 random write pointer");
            end else if (op == 1) begin
                rand_read(9'($urandom), 1 + int'($urandom % 6), "R9 R10 random read");
            end else begin
                cur_read(1 + int'($urandom % 4), 1'($urandom), "R8 R10 random current read");
            end
        end
        finish_up();
    end
endmodule